// File: doc/BRIEF.md
# Preemptive Interrupt Priority Arbiter

This block watches a set of interrupt request lines, each with its own programmable priority value. It decides which pending request is serviced next and whether that request may interrupt the handler that is running now. A grouping input divides every priority value into two parts. The upper bits form a preemption field, which decides nesting. The lower bits form a sub-priority field, which only orders requests that are waiting.

Handlers that are running or interrupted sit on an internal stack, one entry per nesting level. When software reports that a handler has finished, the block does one of two things. It chains straight into the next eligible request without unwinding, or it resumes the interrupted level and restores that level's running priority. A global mask holds every new decision back. Requests stay latched while the mask is set and compete once it is released.

The control is a two-state machine. `ST_IDLE` means no handler is running and `ST_BUSY` means at least one is on the stack. The named transitions are: take (`ST_IDLE`→`ST_BUSY`), preempt (`ST_BUSY`→`ST_BUSY`, push), chain (`ST_BUSY`→`ST_BUSY`, replace top), return to an outer level (`ST_BUSY`→`ST_BUSY`, pop), and final return (`ST_BUSY`→`ST_IDLE`, pop of the last entry). Every strobe is registered. A request whose line rises before clock edge k is latched at edge k and can be taken at edge k+1.

Top module: `irq_prio_arbiter`

## Requirements
- R1: A lower priority value is more urgent, and 0 is the most urgent. Among eligible requests, the one with the smallest whole priority value wins, which means the lowest preemption field and then the lowest sub-priority. On equal values the lower request index wins.
- R2: With `group_sel` = p, the preemption field is the upper p bits of the PRIO_BITS-wide priority value and the sub-priority is the remaining lower bits. p = 0 puts every request in one preemption group, and p = PRIO_BITS leaves no sub-priority.
- R3: A pending request interrupts the running handler only if its preemption field is strictly lower than the running handler's field. On a preemption `take_strobe` and `preempt_flag` pulse together, `vector_idx` gives the new request, and `run_pre` drops to its field.
- R4: A request whose preemption field equals that of the running handler never interrupts it, whatever the sub-priorities are.
- R5: On `handler_done`, the block chains straight to the winning eligible request if one exists and it would preempt the level below the finishing handler (any eligible request qualifies when no level is below). It pulses `tail_chain` instead of `return_strobe`.
- R6: Otherwise `handler_done` pulses `return_strobe`. `vector_idx` and `run_pre` return to the interrupted handler, or `run_valid` falls when no handler remains.
- R7: While `global_mask` is high, no take, preemption or chain happens, and requests that arrive stay pending. A completion under the mask is a plain return. Arbitration resumes on the first edge after the mask is released.
- R8: A request becomes pending on a rising edge of its line, is cleared when it is taken, and cannot be taken again while its handler is still on the stack. A line that stays high does not re-request.
- R9: `take_strobe`, `tail_chain` and `return_strobe` are single-cycle pulses, and at most one of them is high in any cycle. `handler_done` while no handler runs has no effect.
- R10: After reset all strobes are low, `run_valid` is low, and `vector_idx` and `run_pre` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | NUM_IRQ | Request lines, rising edge latches a request |
| prio_cfg | input | NUM_IRQ*PRIO_BITS | Priority value of request i at bits [i*PRIO_BITS +: PRIO_BITS] |
| group_sel | input | $clog2(PRIO_BITS+1) | Number of preemption bits p |
| global_mask | input | 1 | Holds back all take, preempt and chain decisions |
| handler_done | input | 1 | The running handler has finished |
| take_strobe | output | 1 | A request was taken (from idle or by preemption) |
| preempt_flag | output | 1 | The take interrupted a running handler |
| tail_chain | output | 1 | Completion went straight into the next request |
| return_strobe | output | 1 | Completion resumed the interrupted level or went idle |
| vector_idx | output | $clog2(NUM_IRQ) | Index of the request now running |
| run_valid | output | 1 | A handler is running |
| run_pre | output | PRIO_BITS | Preemption field of the running handler, 0 when idle |

## Verification
The assertions check on every cycle that the strobes are exclusive, that a preemption strictly lowers the running field, that a return restores a strictly higher one, that the mask blocks every new entry, and that a completion while idle produces nothing. Only the directed scenarios show that the right request wins. This covers sub-priority ordering, the index tie-break, same-group requests waiting instead of nesting, the choice between chaining and returning, latched requests surviving the mask, and every grouping setting with its expected preemption outcome.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    typedef enum logic [0:0] {
        ST_IDLE,
        ST_BUSY
    } arb_state_t;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_TAKE,
        ACT_PREEMPT,
        ACT_CHAIN,
        ACT_RETURN
    } arb_act_t;

endpackage

// File: rtl/irq_pend_track.sv
module irq_pend_track #(
    parameter int NUM_IRQ = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] req,
    input  logic [NUM_IRQ-1:0] clr,
    output logic [NUM_IRQ-1:0] pend
);

    logic [NUM_IRQ-1:0] req_q;
    logic [NUM_IRQ-1:0] rise;

    assign rise = req & ~req_q;

    // one latch per line; a fresh edge wins over a same-cycle clear
    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                req_q[g] <= 1'b0;
                pend[g]  <= 1'b0;
            end else begin
                req_q[g] <= req[g];
                pend[g]  <= rise[g] | (pend[g] & ~clr[g]);
            end
        end
    end

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int NUM_IRQ   = 8,
    parameter int PRIO_BITS = 3,
    localparam int IW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1,
    localparam int SW = $clog2(PRIO_BITS + 1)
) (
    input  logic [NUM_IRQ-1:0]           cand,
    input  logic [NUM_IRQ*PRIO_BITS-1:0] prio_flat,
    input  logic [SW-1:0]                sub_bits,
    output logic                         found,
    output logic [IW-1:0]                idx,
    output logic [PRIO_BITS-1:0]         pre
);

    logic [PRIO_BITS-1:0] best;
    logic [PRIO_BITS-1:0] val;

    // smallest whole value wins: preemption field sits in the upper bits,
    // so this orders by group first and sub-priority second; strict '<'
    // keeps the lower index on a tie
    always_comb begin
        found = 1'b0;
        best  = '1;
        idx   = '0;
        val   = '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            val = prio_flat[i*PRIO_BITS +: PRIO_BITS];
            if (cand[i] && (!found || (val < best))) begin
                found = 1'b1;
                best  = val;
                idx   = IW'(i);
            end
        end
    end

    assign pre = best >> sub_bits;

endmodule

// File: rtl/irq_active_stack.sv
module irq_active_stack #(
    parameter int NUM_IRQ   = 8,
    parameter int PRIO_BITS = 3,
    localparam int IW    = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1,
    localparam int DEPTH = 1 << PRIO_BITS,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int SPW   = AW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 push,
    input  logic                 pop,
    input  logic                 repl,
    input  logic [IW-1:0]        in_idx,
    input  logic [PRIO_BITS-1:0] in_pre,
    output logic                 top_valid,
    output logic [PRIO_BITS-1:0] top_pre,
    output logic                 below_valid,
    output logic [PRIO_BITS-1:0] below_pre,
    output logic [IW-1:0]        below_idx,
    output logic                 full,
    output logic [NUM_IRQ-1:0]   active_mask
);

    logic [IW-1:0]        idx_q [DEPTH];
    logic [PRIO_BITS-1:0] pre_q [DEPTH];
    logic [SPW-1:0]       sp;
    logic [SPW-1:0]       sp_m1;
    logic [SPW-1:0]       sp_m2;
    logic [SPW-1:0]       wr_ptr;
    logic                 wr_any;

    assign sp_m1  = sp - SPW'(1);
    assign sp_m2  = sp - SPW'(2);
    assign wr_any = push | repl;
    assign wr_ptr = push ? sp : sp_m1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp <= '0;
        end else if (push) begin
            sp <= sp + SPW'(1);
        end else if (pop && (sp != '0)) begin
            sp <= sp_m1;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                idx_q[g] <= '0;
                pre_q[g] <= '0;
            end else if (wr_any && (wr_ptr == SPW'(g))) begin
                idx_q[g] <= in_idx;
                pre_q[g] <= in_pre;
            end
        end
    end

    assign top_valid   = (sp != '0);
    assign below_valid = (sp > SPW'(1));
    assign full        = (sp == SPW'(DEPTH));
    assign top_pre     = top_valid   ? pre_q[sp_m1[AW-1:0]] : '0;
    assign below_pre   = below_valid ? pre_q[sp_m2[AW-1:0]] : '0;
    assign below_idx   = below_valid ? idx_q[sp_m2[AW-1:0]] : '0;

    always_comb begin
        active_mask = '0;
        for (int d = 0; d < DEPTH; d++) begin
            if (SPW'(d) < sp) begin
                active_mask[idx_q[d]] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
    import irq_arb_pkg::*;
#(
    parameter int NUM_IRQ   = 8,
    parameter int PRIO_BITS = 3
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic [NUM_IRQ-1:0]                          irq_req,
    input  logic [NUM_IRQ*PRIO_BITS-1:0]                prio_cfg,
    input  logic [$clog2(PRIO_BITS+1)-1:0]              group_sel,
    input  logic                                        global_mask,
    input  logic                                        handler_done,
    output logic                                        take_strobe,
    output logic                                        preempt_flag,
    output logic                                        tail_chain,
    output logic                                        return_strobe,
    output logic [((NUM_IRQ>1)?$clog2(NUM_IRQ):1)-1:0]  vector_idx,
    output logic                                        run_valid,
    output logic [PRIO_BITS-1:0]                        run_pre
);

    localparam int IW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
    localparam int SW = $clog2(PRIO_BITS + 1);

    arb_state_t state_q, state_nx;
    arb_act_t   act;

    logic [NUM_IRQ-1:0]   pend;
    logic [NUM_IRQ-1:0]   clr;
    logic [NUM_IRQ-1:0]   cand;
    logic [NUM_IRQ-1:0]   active_mask;
    logic [SW-1:0]        p_eff;
    logic [SW-1:0]        sub_bits;
    logic                 win_found;
    logic [IW-1:0]        win_idx;
    logic [PRIO_BITS-1:0] win_pre;
    logic                 top_valid, below_valid, full;
    logic [PRIO_BITS-1:0] top_pre, below_pre;
    logic [IW-1:0]        below_idx;
    logic                 st_push, st_pop, st_repl;

    assign p_eff    = (group_sel > SW'(PRIO_BITS)) ? SW'(PRIO_BITS) : group_sel;
    assign sub_bits = SW'(PRIO_BITS) - p_eff;
    assign cand     = pend & ~active_mask & {NUM_IRQ{~global_mask}};

    irq_pend_track #(.NUM_IRQ(NUM_IRQ)) u_pend (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (irq_req),
        .clr  (clr),
        .pend (pend)
    );

    irq_pick #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS)) u_pick (
        .cand     (cand),
        .prio_flat(prio_cfg),
        .sub_bits (sub_bits),
        .found    (win_found),
        .idx      (win_idx),
        .pre      (win_pre)
    );

    irq_active_stack #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS)) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (st_push),
        .pop        (st_pop),
        .repl       (st_repl),
        .in_idx     (win_idx),
        .in_pre     (win_pre),
        .top_valid  (top_valid),
        .top_pre    (top_pre),
        .below_valid(below_valid),
        .below_pre  (below_pre),
        .below_idx  (below_idx),
        .full       (full),
        .active_mask(active_mask)
    );

    // decision and next state
    always_comb begin
        act      = ACT_NONE;
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (win_found) begin
                    act      = ACT_TAKE;
                    state_nx = ST_BUSY;
                end
            end
            ST_BUSY: begin
                if (handler_done) begin
                    if (win_found && (!below_valid || (win_pre < below_pre))) begin
                        act = ACT_CHAIN;
                    end else begin
                        act = ACT_RETURN;
                        if (!below_valid) begin
                            state_nx = ST_IDLE;
                        end
                    end
                end else if (win_found && !full && (win_pre < top_pre)) begin
                    act = ACT_PREEMPT;
                end
            end
            default: begin
                state_nx = ST_IDLE;
            end
        endcase
    end

    assign st_push = (act == ACT_TAKE) || (act == ACT_PREEMPT);
    assign st_pop  = (act == ACT_RETURN);
    assign st_repl = (act == ACT_CHAIN);

    always_comb begin
        clr = '0;
        if (st_push || st_repl) begin
            clr[win_idx] = 1'b1;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_strobe   <= 1'b0;
            preempt_flag  <= 1'b0;
            tail_chain    <= 1'b0;
            return_strobe <= 1'b0;
            vector_idx    <= '0;
        end else begin
            take_strobe   <= st_push;
            preempt_flag  <= (act == ACT_PREEMPT);
            tail_chain    <= st_repl;
            return_strobe <= st_pop;
            if (st_push || st_repl) begin
                vector_idx <= win_idx;
            end else if (st_pop && below_valid) begin
                vector_idx <= below_idx;
            end
        end
    end

    assign run_valid = top_valid;
    assign run_pre   = top_pre;

endmodule

// File: rtl/irq_prio_arbiter_chk.sv
module irq_prio_arbiter_chk #(
    parameter int PRIO_BITS = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 global_mask,
    input logic                 handler_done,
    input logic                 take_strobe,
    input logic                 preempt_flag,
    input logic                 tail_chain,
    input logic                 return_strobe,
    input logic                 run_valid,
    input logic [PRIO_BITS-1:0] run_pre
);

    assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({take_strobe, tail_chain, return_strobe}));

    assert_preempt_lowers_R3: assert property (@(posedge clk) disable iff (!rst_n)
        preempt_flag |-> (take_strobe && (run_pre < $past(run_pre))));

    assert_return_restores_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (return_strobe && run_valid) |-> (run_pre > $past(run_pre)));

    assert_mask_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        global_mask |=> (!take_strobe && !tail_chain));

    assert_idle_done_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (handler_done && !run_valid) |=> (!return_strobe && !tail_chain));

    assert_chain_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tail_chain |-> run_valid);

endmodule

bind irq_prio_arbiter irq_prio_arbiter_chk #(.PRIO_BITS(PRIO_BITS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .global_mask  (global_mask),
    .handler_done (handler_done),
    .take_strobe  (take_strobe),
    .preempt_flag (preempt_flag),
    .tail_chain   (tail_chain),
    .return_strobe(return_strobe),
    .run_valid    (run_valid),
    .run_pre      (run_pre)
);

// File: tb/irq_prio_arbiter_bench.sv
module irq_prio_arbiter_bench;

    localparam int N  = 8;
    localparam int PB = 3;
    localparam int IW = $clog2(N);
    localparam int GW = $clog2(PB + 1);

    logic              clk = 1'b0;
    logic              rst_n;
    logic [N-1:0]      irq_req;
    logic [PB-1:0]     prio [N];
    logic [N*PB-1:0]   prio_flat;
    logic [GW-1:0]     group_sel;
    logic              global_mask;
    logic              handler_done;
    logic              take_strobe, preempt_flag, tail_chain, return_strobe;
    logic [IW-1:0]     vector_idx;
    logic              run_valid;
    logic [PB-1:0]     run_pre;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    bit s_take, s_pre, s_chain, s_ret;
    int s_vec, n_take;

    always #10 clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) prio_flat[i*PB +: PB] = prio[i];
    end

    irq_prio_arbiter #(.NUM_IRQ(N), .PRIO_BITS(PB)) u_irq_prio_arbiter (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .prio_cfg(prio_flat),
        .group_sel(group_sel), .global_mask(global_mask), .handler_done(handler_done),
        .take_strobe(take_strobe), .preempt_flag(preempt_flag), .tail_chain(tail_chain),
        .return_strobe(return_strobe), .vector_idx(vector_idx),
        .run_valid(run_valid), .run_pre(run_pre)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic watch(int n);
        s_take = 0; s_pre = 0; s_chain = 0; s_ret = 0; s_vec = -1; n_take = 0;
        for (int k = 0; k < n; k++) begin
            tick();
            if (take_strobe) begin s_take = 1; n_take++; s_vec = vector_idx; end
            if (preempt_flag) s_pre = 1;
            if (tail_chain) begin s_chain = 1; s_vec = vector_idx; end
            if (return_strobe) s_ret = 1;
        end
    endtask

    task automatic pulse_done();
        handler_done = 1'b1;
        tick();
        handler_done = 1'b0;
    endtask

    task automatic t_reset();
        chk("R10", "take", take_strobe, 0);
        chk("R10", "chain|ret", tail_chain | return_strobe, 0);
        chk("R10", "run_valid", run_valid, 0);
        chk("R10", "vector", vector_idx, 0);
        chk("R10", "run_pre", run_pre, 0);
    endtask

    task automatic t_basic();
        group_sel = 3;
        prio[2] = 3'd3;
        irq_req[2] = 1'b1;
        tick();
        chk("R8", "no take one edge after rise", take_strobe, 0);
        tick();
        chk("R8", "take on second edge", take_strobe, 1);
        chk("R1", "vector", vector_idx, 2);
        chk("R3", "run_pre", run_pre, 3);
        chk("R3", "preempt from idle", preempt_flag, 0);
        tick();
        chk("R9", "take is one cycle", take_strobe, 0);
        watch(3);
        chk("R8", "steady high line no retake", s_take, 0);
        irq_req[2] = 1'b0; tick();
        irq_req[2] = 1'b1;
        watch(3);
        chk("R8", "active request not retaken", s_take, 0);
        pulse_done();
        chk("R6", "return", return_strobe, 1);
        chk("R6", "idle after return", run_valid, 0);
        tick();
        chk("R8", "re-request taken after completion", take_strobe, 1);
        chk("R8", "re-request vector", vector_idx, 2);
        irq_req[2] = 1'b0;
        pulse_done();
        chk("R6", "second return", return_strobe, 1);
        pulse_done();
        chk("R9", "done while idle", return_strobe | tail_chain | take_strobe, 0);
        chk("R9", "still idle", run_valid, 0);
    endtask

    task automatic t_sub_order();
        group_sel = 2;
        prio[3] = 3'b010; prio[5] = 3'b011; prio[1] = 3'b011;
        global_mask = 1'b1;
        irq_req[1] = 1'b1; irq_req[3] = 1'b1; irq_req[5] = 1'b1;
        watch(5);
        chk("R7", "no take under mask", s_take, 0);
        global_mask = 1'b0;
        watch(3);
        chk("R7", "take after release", s_take, 1);
        chk("R1", "lowest sub wins", s_vec, 3);
        chk("R4", "single take", n_take, 1);
        chk("R2", "run_pre group 2", run_pre, 1);
        watch(3);
        chk("R4", "same group no preempt", s_take, 0);
        pulse_done();
        chk("R5", "chain", tail_chain, 1);
        chk("R5", "no return on chain", return_strobe, 0);
        chk("R1", "index tie-break", vector_idx, 1);
        global_mask = 1'b1;
        pulse_done();
        chk("R7", "masked completion returns", return_strobe, 1);
        chk("R7", "masked completion no chain", tail_chain, 0);
        chk("R6", "idle", run_valid, 0);
        watch(3);
        chk("R7", "still held", s_take, 0);
        global_mask = 1'b0;
        watch(2);
        chk("R7", "held request taken", s_vec, 5);
        irq_req = '0;
        pulse_done();
        chk("R6", "final return", return_strobe, 1);
        chk("R6", "idle at end", run_valid, 0);
    endtask

    task automatic t_preempt();
        group_sel = 2;
        prio[4] = 3'b100; prio[6] = 3'b101; prio[2] = 3'b010;
        irq_req[4] = 1'b1;
        watch(3);
        chk("R3", "outer taken", s_vec, 4);
        irq_req[6] = 1'b1;
        watch(4);
        chk("R4", "equal group waits", s_take, 0);
        irq_req[2] = 1'b1;
        watch(3);
        chk("R3", "preempt", s_pre, 1);
        chk("R3", "preempt vector", s_vec, 2);
        chk("R3", "run_pre lowered", run_pre, 1);
        pulse_done();
        chk("R6", "return not chain", return_strobe, 1);
        chk("R6", "resumed vector", vector_idx, 4);
        chk("R6", "restored run_pre", run_pre, 2);
        pulse_done();
        chk("R5", "chain when stack empties", tail_chain, 1);
        chk("R5", "chain vector", vector_idx, 6);
        irq_req = '0;
        pulse_done();
        chk("R6", "idle", run_valid, 0);
    endtask

    task automatic t_groups();
        logic [PB-1:0] av [2];
        logic [PB-1:0] bv [2];
        av[0] = 3'b100; bv[0] = 3'b010;
        av[1] = 3'b011; bv[1] = 3'b010;
        for (int p = 0; p <= PB; p++) begin
            for (int k = 0; k < 2; k++) begin
                int s = PB - p;
                int exp_pre = ((av[k] >> s) > (bv[k] >> s)) ? 1 : 0;
                group_sel = GW'(p);
                prio[0] = av[k]; prio[7] = bv[k];
                irq_req[0] = 1'b1;
                watch(3);
                chk("R2", "outer taken", s_vec, 0);
                irq_req[7] = 1'b1;
                watch(4);
                chk("R2", $sformatf("preempt p=%0d pair=%0d", p, k), s_pre, exp_pre);
                irq_req = '0;
                for (int c = 0; c < 4; c++) if (run_valid) pulse_done();
                chk("R2", "drained", run_valid, 0);
                tick();
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        irq_req = '0;
        group_sel = 3;
        global_mask = 1'b0;
        handler_done = 1'b0;
        for (int i = 0; i < N; i++) prio[i] = 3'd7;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_basic();
        t_sub_order();
        t_preempt();
        t_groups();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule